// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of event timers and the interrupt fabric. Each timer presents a one-cycle fire strobe, a status bit, and a few configuration bits: interrupt enable, level or edge type, message mode, and a 5-bit line select. It also presents a 64-bit message word. The router turns these into a vector of interrupt lines, or into 32-bit message write requests for a separate bus master to carry out.

A global enable gates all timer-driven interrupts. A legacy replacement mode forces timer 0 onto line 0 and timer 1 onto line 8. In that mode the external PIT and RTC request inputs are blocked from those two lines, and the PIT-enable output is dropped. Level-type lines are derived from the live status and configuration. Any change to an enable, to the type or to the mode therefore takes effect on the line one cycle later.

Top module: `irq_router`

## Requirements
- R1: When `legacy` is 1, timer 0 drives line 0 and timer 1 drives line 8 whatever their route fields hold. Every other timer, and timers 0 and 1 when `legacy` is 0, drive the line numbered by their 5-bit field `tmr_route[5t+4:5t]`.
- R2: A level-type timer (`tmr_level`=1) drives its line high one cycle after `tmr_status`, `tmr_int_en` and `glb_en` are all 1 with `tmr_msg_en` 0. The line falls one cycle after any of these drops or the type changes to edge.
- R3: An edge-type timer with `tmr_int_en`, `glb_en` and a one-cycle `tmr_fire` produces a pulse on its line exactly one cycle wide, one cycle after the fire.
- R4: A fire from a timer with `tmr_msg_en`, `tmr_int_en` and `glb_en` set raises `msg_valid` for one cycle, one cycle later. `msg_addr` carries bits 63:32 of that timer's message word and `msg_data` carries bits 31:0. No interrupt line is driven.
- R5: Message fires that coincide are all issued, one per cycle, lowest timer index first.
- R6: With `legacy` 0, `pit_in` appears on line 0 and `rtc_in` on line 8, two cycles after it is applied.
- R7: With `legacy` 1, lines 0 and 8 carry no PIT or RTC request and `pit_en` is 0 one cycle later. The RTC level keeps being recorded, so one cycle after `legacy` clears, line 8 shows that recorded level and `pit_en` is 1.
- R8: Several timers routed to one line combine as a logical OR.
- R9: During and after reset, `irq` is all 0, `pit_en` is 1, `msg_valid` is 0 and the recorded RTC level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy | input | 1 | Legacy replacement mode |
| tmr_int_en | input | NUM_TIMERS | Per-timer interrupt enable |
| tmr_level | input | NUM_TIMERS | Per-timer type, 1 = level, 0 = edge |
| tmr_msg_en | input | NUM_TIMERS | Per-timer message-write mode |
| tmr_status | input | NUM_TIMERS | Per-timer interrupt status |
| tmr_fire | input | NUM_TIMERS | Per-timer one-cycle fire strobe |
| tmr_route | input | NUM_TIMERS*5 | Per-timer line select, 5 bits each |
| tmr_msg_word | input | NUM_TIMERS*64 | Per-timer message word: address high, data low |
| pit_in | input | 1 | External PIT request level |
| rtc_in | input | 1 | External RTC request level |
| irq | output | NUM_LINES | Interrupt lines |
| pit_en | output | 1 | PIT enable, low in legacy mode |
| msg_valid | output | 1 | One-cycle message write request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The level path is swept over every timer and every line value, once with legacy mode off and once with it on. This separates plain route decoding from the legacy override of timers 0 and 1. The edge path gets the same sweep and is checked in the cycle after the pulse, which catches a pulse that is too wide or lands on the wrong line.

All sixteen combinations of global enable, interrupt enable, type and message mode are applied to one timer. This shows which gate blocks a line and which gate blocks a message. Further sequences cover:
- a burst of simultaneous message fires, to check ordering and loss;
- two timers sharing a line;
- PIT and RTC levels toggled while legacy mode is entered and left, to check masking and the recorded RTC level.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // lines claimed by timers 0 and 1 in legacy replacement mode
  localparam int unsigned LEG_LINE_A = 0;
  localparam int unsigned LEG_LINE_B = 8;
  localparam int unsigned WORD_W     = 64;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_word_t;
endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
  import irq_router_pkg::*;
#(
  parameter int unsigned NT = 8,
  parameter int unsigned NL = 32,
  parameter int unsigned RW = 5
) (
  input  logic [NT-1:0]    lvl_req,
  input  logic [NT-1:0]    edge_req,
  input  logic [NT*RW-1:0] route,
  input  logic             legacy,
  output logic [NL-1:0]    line_req
);
  localparam logic [NL-1:0] ONE = {{(NL-1){1'b0}}, 1'b1};

  logic [NL-1:0] contrib [NT];

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [RW-1:0] fld;
    logic [RW-1:0] eff;
    assign fld = route[t*RW +: RW];
    if (t == 0) begin : g_leg_a
      assign eff = legacy ? RW'(LEG_LINE_A) : fld;
    end else if (t == 1) begin : g_leg_b
      assign eff = legacy ? RW'(LEG_LINE_B) : fld;
    end else begin : g_plain
      assign eff = fld;
    end
    assign contrib[t] = (lvl_req[t] | edge_req[t]) ? (ONE << eff) : '0;
  end

  always_comb begin
    line_req = '0;
    for (int t = 0; t < NT; t++) begin
      line_req = line_req | contrib[t];
    end
  end
endmodule

// File: rtl/irq_legacy_gate.sv
module irq_legacy_gate
  import irq_router_pkg::*;
#(
  parameter int unsigned NL = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          legacy,
  input  logic          pit_in,
  input  logic          rtc_in,
  output logic [NL-1:0] pass_lines,
  output logic          pit_en
);
  logic pit_q, pit_d;
  logic rtc_q, rtc_d;
  logic pen_q, pen_d;

  always_comb begin
    pit_d = pit_in;
    rtc_d = rtc_in;
    pen_d = ~legacy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_q <= 1'b0;
      rtc_q <= 1'b0;
      pen_q <= 1'b1;
    end else begin
      pit_q <= pit_d;
      rtc_q <= rtc_d;
      pen_q <= pen_d;
    end
  end

  always_comb begin
    pass_lines             = '0;
    pass_lines[LEG_LINE_A] = pit_q & ~legacy;
    pass_lines[LEG_LINE_B] = rtc_q & ~legacy;
  end

  assign pit_en = pen_q;
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
  import irq_router_pkg::*;
#(
  parameter int unsigned NT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT-1:0]      req,
  input  logic [NT*WORD_W-1:0] words,
  output logic               msg_valid,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic [NT-1:0] pend_q, pend_d;
  logic [NT-1:0] cand, grant;
  msg_word_t     sel_word, word_q;
  logic          vld_q, vld_d;

  always_comb begin
    cand     = pend_q | req;
    grant    = cand & (~cand + NT'(1));
    pend_d   = cand & ~grant;
    vld_d    = |cand;
    sel_word = '0;
    for (int i = 0; i < NT; i++) begin
      if (grant[i]) sel_word = sel_word | words[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      if (vld_d) word_q <= sel_word;
    end
  end

  assign msg_valid = vld_q;
  assign msg_addr  = word_q.addr;
  assign msg_data  = word_q.data;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 8,
  parameter int unsigned NUM_LINES  = 32,
  localparam int unsigned RW        = $clog2(NUM_LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         glb_en,
  input  logic                         legacy,
  input  logic [NUM_TIMERS-1:0]        tmr_int_en,
  input  logic [NUM_TIMERS-1:0]        tmr_level,
  input  logic [NUM_TIMERS-1:0]        tmr_msg_en,
  input  logic [NUM_TIMERS-1:0]        tmr_status,
  input  logic [NUM_TIMERS-1:0]        tmr_fire,
  input  logic [NUM_TIMERS*RW-1:0]     tmr_route,
  input  logic [NUM_TIMERS*WORD_W-1:0] tmr_msg_word,
  input  logic                         pit_in,
  input  logic                         rtc_in,
  output logic [NUM_LINES-1:0]         irq,
  output logic                         pit_en,
  output logic                         msg_valid,
  output logic [31:0]                  msg_addr,
  output logic [31:0]                  msg_data
);
  logic [NUM_TIMERS-1:0] active, lvl_req, edge_req, msg_req;
  logic [NUM_LINES-1:0]  map_lines, pass_lines, irq_d, irq_q;

  always_comb begin
    active   = tmr_int_en & {NUM_TIMERS{glb_en}};
    lvl_req  = active & ~tmr_msg_en & tmr_level & tmr_status;
    edge_req = active & ~tmr_msg_en & ~tmr_level & tmr_fire;
    msg_req  = active & tmr_msg_en & tmr_fire;
  end

  irq_line_map #(.NT(NUM_TIMERS), .NL(NUM_LINES), .RW(RW)) u_map (
    .lvl_req  (lvl_req),
    .edge_req (edge_req),
    .route    (tmr_route),
    .legacy   (legacy),
    .line_req (map_lines)
  );

  irq_legacy_gate #(.NL(NUM_LINES)) u_leg (
    .clk        (clk),
    .rst_n      (rst_n),
    .legacy     (legacy),
    .pit_in     (pit_in),
    .rtc_in     (rtc_in),
    .pass_lines (pass_lines),
    .pit_en     (pit_en)
  );

  irq_msg_arb #(.NT(NUM_TIMERS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (msg_req),
    .words     (tmr_msg_word),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

  always_comb irq_d = map_lines | pass_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_TIMERS = 8,
  parameter int unsigned NUM_LINES  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  glb_en,
  input logic                  legacy,
  input logic [NUM_TIMERS-1:0] tmr_int_en,
  input logic [NUM_TIMERS-1:0] tmr_msg_en,
  input logic [NUM_TIMERS-1:0] tmr_fire,
  input logic [NUM_LINES-1:0]  irq,
  input logic                  pit_en,
  input logic                  msg_valid
);
  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_state_chk: assert (irq == '0 && pit_en && !msg_valid);
    end
  end

  // R7
  pit_en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacy) |=> !pit_en);

  // R7
  legacy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(legacy) && $past(tmr_int_en) == '0) |-> irq == '0);

  // R2
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(legacy) && !$past(glb_en)) |-> irq == '0);

  // R4
  msg_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(glb_en) && |($past(tmr_fire) & $past(tmr_msg_en) & $past(tmr_int_en)))
    |-> msg_valid);
endmodule

bind irq_router irq_router_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .NUM_LINES  (NUM_LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .legacy     (legacy),
  .tmr_int_en (tmr_int_en),
  .tmr_msg_en (tmr_msg_en),
  .tmr_fire   (tmr_fire),
  .irq        (irq),
  .pit_en     (pit_en),
  .msg_valid  (msg_valid)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int NT = 8;
  localparam int NL = 32;
  localparam int RW = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              glb_en = 1'b0, legacy = 1'b0;
  logic [NT-1:0]     tmr_int_en = '0, tmr_level = '0, tmr_msg_en = '0;
  logic [NT-1:0]     tmr_status = '0, tmr_fire = '0;
  logic [NT*RW-1:0]  tmr_route = '0;
  logic [NT*64-1:0]  tmr_msg_word = '0;
  logic              pit_in = 1'b0, rtc_in = 1'b0;
  logic [NL-1:0]     irq;
  logic              pit_en, msg_valid;
  logic [31:0]       msg_addr, msg_data;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy(legacy),
    .tmr_int_en(tmr_int_en), .tmr_level(tmr_level), .tmr_msg_en(tmr_msg_en),
    .tmr_status(tmr_status), .tmr_fire(tmr_fire), .tmr_route(tmr_route),
    .tmr_msg_word(tmr_msg_word), .pit_in(pit_in), .rtc_in(rtc_in),
    .irq(irq), .pit_en(pit_en), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NL-1:0] bit_at(input int n);
    return {{(NL-1){1'b0}}, 1'b1} << n;
  endfunction

  function automatic int line_of(input int t, input int r, input logic leg);
    if (leg && t == 0) return 0;
    if (leg && t == 1) return 8;
    return r;
  endfunction

  function automatic logic [63:0] word_of(input int t);
    return {32'h8000_1000 + 32'(t * 4), 32'hD00D_0000 | 32'(t)};
  endfunction

  task automatic clear_all();
    tmr_int_en = '0; tmr_level = '0; tmr_msg_en = '0;
    tmr_status = '0; tmr_fire = '0; tmr_route = '0;
    legacy = 1'b0; pit_in = 1'b0; rtc_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset irq", 64'(irq), 64'd0);
    chk("R9 reset pit_en", 64'(pit_en), 64'd1);
    chk("R9 reset msg_valid", 64'(msg_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 recorded rtc level after reset", 64'(irq[8]), 64'd0);

    for (int t = 0; t < NT; t++) tmr_msg_word[t*64 +: 64] = word_of(t);
    glb_en = 1'b1;

    // R1 / R2 level sweep with and without legacy mode
    for (int leg = 0; leg < 2; leg++) begin
      for (int t = 0; t < NT; t++) begin
        for (int r = 0; r < NL; r++) begin
          tmr_int_en = '0; tmr_level = '0; tmr_status = '0; tmr_route = '0;
          legacy = leg[0];
          tmr_int_en[t] = 1'b1; tmr_level[t] = 1'b1; tmr_status[t] = 1'b1;
          tmr_route[t*RW +: RW] = RW'(r);
          @(negedge clk);
          chk((leg != 0 && t < 2) ? "R1 legacy route" : "R2 level route",
              64'(irq), 64'(bit_at(line_of(t, r, leg[0]))));
        end
      end
    end
    clear_all();

    // R3 edge sweep
    for (int t = 0; t < NT; t++) begin
      for (int r = 0; r < NL; r++) begin
        tmr_int_en = '0; tmr_route = '0;
        tmr_int_en[t] = 1'b1; tmr_route[t*RW +: RW] = RW'(r);
        tmr_fire[t] = 1'b1;
        @(negedge clk);
        chk("R3 edge pulse line", 64'(irq), 64'(bit_at(r)));
        tmr_fire = '0;
        @(negedge clk);
        chk("R3 edge pulse width", 64'(irq), 64'd0);
      end
    end
    clear_all();

    // gating sweep on timer 2, route 5
    for (int g = 0; g < 16; g++) begin
      logic ge, ie, lv, me;
      ge = g[0]; ie = g[1]; lv = g[2]; me = g[3];
      glb_en = ge;
      tmr_int_en[2] = ie; tmr_level[2] = lv; tmr_msg_en[2] = me;
      tmr_route[2*RW +: RW] = 5'd5;
      tmr_status[2] = 1'b1; tmr_fire[2] = 1'b1;
      @(negedge clk);
      chk("R2 R3 gate fire cycle", 64'(irq), (ge && ie && !me) ? 64'(bit_at(5)) : 64'd0);
      chk("R4 gate msg", 64'(msg_valid), 64'(ge && ie && me));
      tmr_fire = '0;
      @(negedge clk);
      chk("R2 gate hold cycle", 64'(irq), (ge && ie && !me && lv) ? 64'(bit_at(5)) : 64'd0);
      chk("R4 gate msg once", 64'(msg_valid), 64'd0);
      tmr_status = '0;
      @(negedge clk);
    end
    glb_en = 1'b1;
    clear_all();

    // R2 level re-evaluation on timer 4, route 12
    tmr_int_en[4] = 1'b1; tmr_level[4] = 1'b1; tmr_status[4] = 1'b1;
    tmr_route[4*RW +: RW] = 5'd12;
    @(negedge clk); chk("R2 level on", 64'(irq), 64'(bit_at(12)));
    tmr_level[4] = 1'b0;
    @(negedge clk); chk("R2 level to edge lowers", 64'(irq), 64'd0);
    tmr_level[4] = 1'b1;
    @(negedge clk); chk("R2 back to level", 64'(irq), 64'(bit_at(12)));
    tmr_int_en[4] = 1'b0;
    @(negedge clk); chk("R2 enable off lowers", 64'(irq), 64'd0);
    tmr_int_en[4] = 1'b1;
    @(negedge clk); chk("R2 enable with status raises", 64'(irq), 64'(bit_at(12)));
    glb_en = 1'b0;
    @(negedge clk); chk("R2 global off lowers", 64'(irq), 64'd0);
    glb_en = 1'b1;
    @(negedge clk); chk("R2 global on re-raises", 64'(irq), 64'(bit_at(12)));
    clear_all();

    // R4 message per timer
    for (int t = 0; t < NT; t++) begin
      tmr_msg_en = '0; tmr_int_en = '0;
      tmr_msg_en[t] = 1'b1; tmr_int_en[t] = 1'b1; tmr_route[t*RW +: RW] = RW'(t + 3);
      tmr_fire[t] = 1'b1;
      @(negedge clk);
      chk("R4 msg valid", 64'(msg_valid), 64'd1);
      chk("R4 msg addr", 64'(msg_addr), 64'(word_of(t) >> 32));
      chk("R4 msg data", 64'(msg_data), 64'(word_of(t) & 64'hFFFF_FFFF));
      chk("R4 msg no line", 64'(irq), 64'd0);
      tmr_fire = '0;
      @(negedge clk);
    end
    clear_all();

    // R5 simultaneous message fires
    tmr_msg_en = '1; tmr_int_en = '1; tmr_fire = '1;
    for (int k = 0; k < NT; k++) begin
      @(negedge clk);
      tmr_fire = '0;
      chk("R5 burst valid", 64'(msg_valid), 64'd1);
      chk("R5 burst order", 64'(msg_data), 64'(word_of(k) & 64'hFFFF_FFFF));
    end
    @(negedge clk);
    chk("R5 burst drained", 64'(msg_valid), 64'd0);
    clear_all();

    // R8 shared line
    tmr_int_en[2] = 1'b1; tmr_level[2] = 1'b1; tmr_status[2] = 1'b1;
    tmr_int_en[3] = 1'b1; tmr_level[3] = 1'b1; tmr_status[3] = 1'b1;
    tmr_route[2*RW +: RW] = 5'd7; tmr_route[3*RW +: RW] = 5'd7;
    @(negedge clk); chk("R8 both active", 64'(irq), 64'(bit_at(7)));
    tmr_status[2] = 1'b0;
    @(negedge clk); chk("R8 one active", 64'(irq), 64'(bit_at(7)));
    tmr_status[3] = 1'b0;
    @(negedge clk); chk("R8 none active", 64'(irq), 64'd0);
    clear_all();

    // R6 / R7 pass-through and legacy masking
    pit_in = 1'b1;
    repeat (2) @(negedge clk); chk("R6 pit to line 0", 64'(irq), 64'(bit_at(0)));
    rtc_in = 1'b1;
    repeat (2) @(negedge clk); chk("R6 rtc to line 8", 64'(irq), 64'(bit_at(0) | bit_at(8)));
    legacy = 1'b1;
    @(negedge clk);
    chk("R7 legacy masks lines", 64'(irq), 64'd0);
    chk("R7 legacy drops pit_en", 64'(pit_en), 64'd0);
    legacy = 1'b0;
    @(negedge clk);
    chk("R7 legacy clear restores", 64'(irq), 64'(bit_at(0) | bit_at(8)));
    chk("R7 legacy clear pit_en", 64'(pit_en), 64'd1);
    legacy = 1'b1; rtc_in = 1'b0; pit_in = 1'b0;
    repeat (3) @(negedge clk);
    rtc_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 masked while rtc high", 64'(irq), 64'd0);
    legacy = 1'b0;
    @(negedge clk);
    chk("R7 recorded rtc level shown", 64'(irq), 64'(bit_at(8)));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule